// File: doc/BRIEF.md
# Carry-Select Adder with Excess-One Upper Groups

This block is a purely combinational binary adder of parameterised width, 16 bits by default. It returns the sum of two unsigned operands and a carry-in, plus a carry-out. The operands are split into 4-bit groups.

The least significant group is a plain ripple adder, fed by the external carry-in. Every higher group computes its result once, assuming no incoming carry. An excess-one incrementer then derives the result for an incoming carry of one from that first result. It does not use a second ripple adder. The carry that actually reaches the group selects between the two results. Four sum multiplexers and one carry multiplexer make that choice. The selected carry then steers the next group.

The block suits datapaths that need a shorter carry path than a full ripple adder. Those datapaths must also avoid the area of a duplicated adder per group. It has no clock and holds no state.

Top module: `csa_bec_adder`

## Requirements
- R1: For every input combination, the 1-bit carry-out followed by the WIDTH-bit sum equals a + b + cin, computed as an unsigned (WIDTH+1)-bit value.
- R2: The lowest 4-bit group adds a[3:0], b[3:0] and cin directly. Its 5-bit result equals that 5-bit sum, so a carry-in alone can carry out of the group (for example 0x000F + 0x0000 + 1 = 0x0010).
- R3: When no carry reaches an upper group, that group's 4 sum bits and carry-out equal the plain sum of its operand slices.
- R4: When a carry reaches an upper group, that group's 4 sum bits and carry-out equal the sum of its operand slices plus one.
- R5: A carry can travel from cin through every group to cout (for example all-ones + 0 + 1 gives sum 0 and cout 1).
- R6: Each incrementer returns its 5-bit input plus one, modulo 32.
- R7: cout equals bit WIDTH of a + b + cin, which is the carry selected in the most significant group.
- R8: WIDTH must be a non-zero multiple of 4. Any other value stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
The hardest case to reach is an upper group that outputs its incremented result while its own slices all ones. Here the incoming carry must pass straight through the group. That happens only when the group below also produces a carry, so the carry chain has to be long. Random operands seldom line up this way. The vector table therefore holds operands that are all ones, or all ones in selected groups, paired with a carry-in. An exhaustive sweep of an 8-bit instance covers every combination of select value and incrementer input for one upper group.

// File: rtl/csa_pkg.sv
// Package: shared constants for the carry-select adder.
// Assumes: every upper group is GRP_W bits wide; the incrementer is one bit wider.
package csa_pkg;
    localparam int GRP_W = 4;
    localparam int INC_W = GRP_W + 1;
endpackage

// File: rtl/csa_fa.sv
// Module: one-bit full adder, the cell of each ripple group.
// Assumes: nothing; pure combinational logic.
module csa_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and majority carry of three input bits.
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (x & ci) | (y & ci);
    end
endmodule

// File: rtl/csa_rca_grp.sv
// Module: GW-bit ripple adder built from a chain of full adders.
// Assumes: ci is held constant at 0 for upper groups and tied to cin for the lowest group.
module csa_rca_grp #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a,
    input  logic [GW-1:0] b,
    input  logic          ci,
    output logic [GW-1:0] s,
    output logic          co
);
    logic [GW:0] chain;

    assign chain[0] = ci;

    for (genvar i = 0; i < GW; i++) begin : g_bit
        csa_fa u_fa (
            .x  (a[i]),
            .y  (b[i]),
            .ci (chain[i]),
            .s  (s[i]),
            .co (chain[i+1])
        );
    end

    assign co = chain[GW];

    // R2 (and R3 for upper groups): the ripple result equals the arithmetic sum of the slices.
    always_comb begin
        if (!$isunknown({a, b, ci})) begin
            p_ripple_sum_r2: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{GW{1'b0}}, ci}))
                else $error("ripple group result mismatch");
        end
    end
endmodule

// File: rtl/csa_bec_inc.sv
// Module: binary to excess-one converter. It adds one to a W-bit value using
// a prefix-AND chain instead of an adder.
// Assumes: the input is the carry-in-0 result {carry, sum} of one group.
module csa_bec_inc #(
    parameter int W = 5
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    logic [W-1:0] all_low_ones;

    assign all_low_ones[0] = 1'b1;

    for (genvar k = 1; k < W; k++) begin : g_pref
        assign all_low_ones[k] = all_low_ones[k-1] & x[k-1];
    end

    for (genvar k = 0; k < W; k++) begin : g_flip
        assign y[k] = x[k] ^ all_low_ones[k];
    end

    // R6: the converter output is the input plus one, wrapping at 2**W.
    always_comb begin
        if (!$isunknown(x)) begin
            p_bec_plus_one_r6: assert (y == W'(x + W'(1)))
                else $error("incrementer result mismatch");
        end
    end
endmodule

// File: rtl/csa_sel_grp.sv
// Module: picks the carry-in-0 or carry-in-1 result of one upper group.
// Assumes: sel is the real carry entering the group; inc is {c0,s0}+1.
module csa_sel_grp #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] s0,
    input  logic          c0,
    input  logic [GW:0]   inc,
    input  logic          sel,
    output logic [GW-1:0] s,
    output logic          co
);
    // One two-way multiplexer per sum bit.
    for (genvar i = 0; i < GW; i++) begin : g_mux
        assign s[i] = sel ? inc[i] : s0[i];
    end

    // Carry multiplexer; its output steers the next group.
    assign co = sel ? inc[GW] : c0;
endmodule

// File: rtl/csa_bec_adder.sv
// Module: top of the carry-select adder. The lowest group ripples from cin.
// Each upper group pairs a carry-in-0 ripple adder with an incrementer and a
// selector driven by the carry from the group below.
// Assumes: WIDTH is a non-zero multiple of csa_pkg::GRP_W; combinational only.
module csa_bec_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import csa_pkg::*;

    localparam int NGRP = WIDTH / GRP_W;

    // R8: reject widths that do not split into whole groups.
    if ((WIDTH % GRP_W) != 0 || WIDTH == 0) begin : g_bad_width
        $error("csa_bec_adder: WIDTH must be a non-zero multiple of 4");
    end

    logic [NGRP:0] cgrp;

    assign cgrp[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        if (g == 0) begin : g_low
            csa_rca_grp #(.GW(GRP_W)) u_rca (
                .a  (a[GRP_W-1:0]),
                .b  (b[GRP_W-1:0]),
                .ci (cgrp[0]),
                .s  (sum[GRP_W-1:0]),
                .co (cgrp[1])
            );
        end else begin : g_up
            logic [GRP_W-1:0] s0;
            logic             c0;
            logic [INC_W-1:0] inc;

            csa_rca_grp #(.GW(GRP_W)) u_rca (
                .a  (a[g*GRP_W +: GRP_W]),
                .b  (b[g*GRP_W +: GRP_W]),
                .ci (1'b0),
                .s  (s0),
                .co (c0)
            );

            csa_bec_inc #(.W(INC_W)) u_inc (
                .x ({c0, s0}),
                .y (inc)
            );

            csa_sel_grp #(.GW(GRP_W)) u_sel (
                .s0  (s0),
                .c0  (c0),
                .inc (inc),
                .sel (cgrp[g]),
                .s   (sum[g*GRP_W +: GRP_W]),
                .co  (cgrp[g+1])
            );

            // R3/R4: the selected group result equals slice sum plus the incoming carry.
            always_comb begin
                if (!$isunknown({a, b, cin})) begin
                    p_group_sel_r4: assert ({cgrp[g+1], sum[g*GRP_W +: GRP_W]} ==
                                            ({1'b0, a[g*GRP_W +: GRP_W]} + {1'b0, b[g*GRP_W +: GRP_W]}
                                             + {{GRP_W{1'b0}}, cgrp[g]}))
                        else $error("upper group selection mismatch");
                end
            end
        end
    end

    assign cout = cgrp[NGRP];

    // R1 and R7: the whole result and its top bit match the arithmetic sum.
    always_comb begin
        if (!$isunknown({a, b, cin})) begin
            p_total_sum_r1: assert ({cout, sum} ==
                                    ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
                else $error("adder total mismatch");
            p_carry_out_r7: assert (cout ==
                                    (({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}) >> WIDTH))
                else $error("carry out mismatch");
        end
    end
endmodule

// File: tb/csa_bec_adder_bench.sv
`timescale 1ns/1ps
module csa_bec_adder_bench;
    localparam int W = 16;
    localparam int N = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, sum;
    logic         cin, cout;
    logic [7:0]   a8, b8, sum8;
    logic         cin8, cout8;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    csa_bec_adder #(.WIDTH(W)) u_csa_bec_adder (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    csa_bec_adder #(.WIDTH(8)) u_csa_bec_adder_w8 (
        .a(a8), .b(b8), .cin(cin8), .sum(sum8), .cout(cout8)
    );

    // Each entry: {a, b, cin, expected {cout,sum}}.
    localparam logic [49:0] VEC [0:N-1] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h00000},
        {16'h000F, 16'h0000, 1'b1, 17'h00010},
        {16'h00F5, 16'h000B, 1'b0, 17'h00100},
        {16'h0120, 16'h0340, 1'b0, 17'h00460},
        {16'h1234, 16'h4321, 1'b0, 17'h05555},
        {16'h00FF, 16'h0001, 1'b0, 17'h00100},
        {16'h0FFF, 16'h0000, 1'b1, 17'h01000},
        {16'h7FFF, 16'h0001, 1'b0, 17'h08000},
        {16'h8000, 16'h8000, 1'b0, 17'h10000},
        {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
        {16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
        {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
        {16'hFFF0, 16'h000F, 1'b0, 17'h0FFFF}
    };

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles >= 200000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 200000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; cin = 1'b0;
        a8 = '0; b8 = '0; cin8 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle outputs with zero inputs.
        check("R1 zero inputs", {cout, sum}, 17'h0);

        // Table walk: R1, R2 (entry 1), R3 (3), R4 (2), R5 (9, 11), R7 (8, 10).
        for (int i = 0; i < N; i++) begin
            a = VEC[i][49:34]; b = VEC[i][33:18]; cin = VEC[i][17];
            #1;
            check($sformatf("R1 table %0d", i), {cout, sum}, VEC[i][16:0]);
        end

        // R5: a carry from cin runs through every group.
        a = '1; b = '0; cin = 1'b1; #1;
        check("R5 full chain sum", {16'h0, sum}, 17'h0);
        check("R7 full chain cout", {16'h0, cout}, 17'h1);

        // R4: selected carry reaches the top group only through incremented middles.
        a = 16'h0FF8; b = 16'h0008; cin = 1'b0; #1;
        check("R4 incremented middles", {cout, sum}, 17'h01000);

        // R3: upper groups keep their plain sum when the low group has no carry.
        a = 16'h9870; b = 16'h0120; cin = 1'b1; #1;
        check("R3 plain upper groups", {cout, sum}, 17'h09991);

        // R1, R3, R4, R6: exhaustive 8-bit sweep covering every select/increment input.
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int c = 0; c < 2; c++) begin
                    a8 = 8'(x); b8 = 8'(y); cin8 = 1'(c);
                    #1;
                    check("R1 exhaustive w8", {8'h0, cout8, sum8}, 17'(x + y + c));
                end
            end
        end

        // R1: random 16-bit operands.
        for (int i = 0; i < 3000; i++) begin
            a = 16'($urandom); b = 16'($urandom); cin = 1'($urandom);
            #1;
            check("R1 random", {cout, sum}, 17'({1'b0, a} + {1'b0, b} + {16'h0, cin}));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule